// File: doc/BRIEF.md
# Dual-Output Glitchless Clock Selector

This block drives two system clock outputs. Each output runs either from a standby clock that both outputs share, or from its own PLL output. The switch between the two sources is made by a handshake, so an output never shows a runt pulse or a glitch. A small configuration register, written through a single-cycle write port in the configuration clock domain, holds one select bit per output and one bit that picks which of two reference clocks feeds the standby clock. The standby clock is itself built by a glitchless switch of the same kind.

A PLL lock input gates the PLL selection. A select bit that is written while lock is low waits until lock rises. If lock falls later, the output goes back to the standby clock. A status bit for each output, in the configuration domain, reports the source that is actually active once its handshake has completed.

Top module: `dual_clk_selector`

## Requirements
- R1: Write-data bit 0 selects the source of `clk_out[0]`: 0 gives the standby clock and 1 gives `clk_pll[0]` (when lock is high).
- R2: Write-data bit 1 selects the source of `clk_out[1]` in the same way, using `clk_pll[1]`. Code 2'b11 puts both outputs on their PLLs, and the two bits act independently.
- R3: After reset both select bits are 0, the standby source bit is 0, both outputs run from the standby clock, and `src_stat` reads 2'b00.
- R4: Write-data bit 4 picks the standby source for both outputs: 0 selects `clk_sys` (the power-on default) and 1 selects `clk_alt`.
- R5: An output is moved to its PLL only while the synchronised `pll_lock` is high. A select bit written while lock is low is held and takes effect when lock rises. A fall of lock returns both outputs to the standby clock.
- R6: No high or low phase on either output is shorter than the shorter half-period of the two clocks involved in a switch.
- R7: A switch first disables the old source after two falling edges of the old clock, and then enables the new source after two falling edges of the new clock. The two sources of one switch are never enabled together, so the status cannot change within four configuration cycles of the write.
- R8: `src_stat[i]` is 1 when `clk_out[i]` runs from its PLL and 0 when it runs from standby. It changes only after the handshake has finished, three configuration cycles after the new source is enabled.
- R9: Write-data bits 3:2 are ignored: writing them has no effect on either output or on the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cfg | input | 1 | Configuration and status clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of the slowest clock |
| wr_en | input | 1 | Write strobe for the configuration register |
| wr_data | input | 5 | Bits 1:0 output selects, bits 3:2 ignored, bit 4 standby source |
| pll_lock | input | 1 | Asynchronous lock indication from the PLL |
| clk_sys | input | 1 | Standby reference 0 (power-on default) |
| clk_alt | input | 1 | Standby reference 1 |
| clk_pll | input | 2 | PLL output clock for each output |
| clk_out | output | 2 | Glitch-free switched output clocks |
| src_stat | output | 2 | Active source per output, 1 = PLL |

## Verification
A write reaches the select register on the next configuration edge. The gated request is registered one edge later, after a two-stage lock synchroniser. The switch then takes two falling edges of the old clock and two of the new clock, and the status follows two synchroniser stages plus one register later. The worst case with the slowest 22 ns reference is therefore well under 30 configuration cycles. The bench waits 80 cycles after every write before it samples the status at a falling configuration edge and measures the output periods. It samples once at four cycles to confirm that the status has not yet changed. Glitches are caught by a monitor that timestamps every edge of both outputs for the whole run.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
package gcs_pkg;
  localparam int NUM_OUT     = 2;
  localparam int WR_W        = 5;
  localparam int SEL_LSB     = 0;
  localparam int SB_BIT      = 4;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/gcs_sync.sv
`timescale 1ns/1ps
module gcs_sync #(
  parameter int STAGES  = 2,
  parameter bit NEG     = 1'b0,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (NEG) begin : g_neg
      always_ff @(negedge clk) begin
        if (rst) ff <= {STAGES{RST_VAL}};
        else     ff <= {ff[STAGES-2:0], d};
      end
    end else begin : g_pos
      always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{RST_VAL}};
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/gcs_glitch_mux.sv
`timescale 1ns/1ps
module gcs_glitch_mux #(
  parameter int STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst,
  input  logic sel_b,
  output logic clk_o,
  output logic en_a,
  output logic en_b
);
  logic req_a, req_b;

  // each side asks only while the other side is off
  assign req_a = ~sel_b & ~en_b;
  assign req_b =  sel_b & ~en_a;

  gcs_sync #(.STAGES(STAGES), .NEG(1'b1), .RST_VAL(1'b1)) u_sync_a (
    .clk(clk_a), .rst(rst), .d(req_a), .q(en_a)
  );

  gcs_sync #(.STAGES(STAGES), .NEG(1'b1), .RST_VAL(1'b0)) u_sync_b (
    .clk(clk_b), .rst(rst), .d(req_b), .q(en_b)
  );

  assign clk_o = (clk_a & en_a) | (clk_b & en_b);

  // R7: both sources of one switch never enabled together
  always_comb begin
    if (rst === 1'b0) begin
      p_one_src_r7: assert (!(en_a && en_b))
        else $error("both clock sources enabled");
    end
  end
endmodule

// File: rtl/gcs_cfg.sv
`timescale 1ns/1ps
module gcs_cfg
  import gcs_pkg::*;
#(
  parameter int N      = NUM_OUT,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  input  logic            pll_lock,
  input  logic [N-1:0]    en_pll,
  input  logic [N-1:0]    en_stby,
  output logic [N-1:0]    eff_sel,
  output logic            sb_sel,
  output logic [N-1:0]    stat
);
  logic [N-1:0] sel_q, eff_q, stat_q, pll_s, stby_s;
  logic         sb_q, lock_s;
  logic         unused_rsvd;

  assign unused_rsvd = ^wr_data[SB_BIT-1:SEL_LSB+N];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      sb_q  <= 1'b0;
    end else if (wr_en) begin
      sel_q <= wr_data[SEL_LSB +: N];
      sb_q  <= wr_data[SB_BIT];
    end
  end

  gcs_sync #(.STAGES(STAGES)) u_lock_sync (
    .clk(clk), .rst(rst), .d(pll_lock), .q(lock_s)
  );

  always_ff @(posedge clk) begin
    if (rst) eff_q <= '0;
    else     eff_q <= sel_q & {N{lock_s}};
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_stat
      gcs_sync #(.STAGES(STAGES)) u_pll_s (
        .clk(clk), .rst(rst), .d(en_pll[i]), .q(pll_s[i])
      );
      gcs_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_stby_s (
        .clk(clk), .rst(rst), .d(en_stby[i]), .q(stby_s[i])
      );

      always_ff @(posedge clk) begin
        if (rst)                       stat_q[i] <= 1'b0;
        else if (pll_s[i] & ~stby_s[i]) stat_q[i] <= 1'b1;
        else if (stby_s[i] & ~pll_s[i]) stat_q[i] <= 1'b0;
      end

      // R8: status moves only once the handshake has settled on one side
      p_stat_settled_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_q[i] != $past(stat_q[i])) |-> ($past(pll_s[i]) != $past(stby_s[i])))
        else $error("status changed mid-handshake");
    end
  endgenerate

  assign eff_sel = eff_q;
  assign sb_sel  = sb_q;
  assign stat    = stat_q;

  // R3: reset clears selects, standby source and status
  p_rst_clear_r3: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && sel_q == '0 && !sb_q && eff_q == '0))
    else $error("reset state wrong");

  // R5: no PLL request passes while lock is low
  p_hold_nolock_r5: assert property (@(posedge clk) disable iff (rst)
    !lock_s |=> (eff_q == '0))
    else $error("PLL requested without lock");
endmodule

// File: rtl/dual_clk_selector.sv
`timescale 1ns/1ps
module dual_clk_selector
  import gcs_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic               clk_cfg,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WR_W-1:0]    wr_data,
  input  logic               pll_lock,
  input  logic               clk_sys,
  input  logic               clk_alt,
  input  logic [NUM_OUT-1:0] clk_pll,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] src_stat
);
  logic [NUM_OUT-1:0] eff_sel, en_pll, en_stby;
  logic               sb_sel, stby_clk;
  logic               sb_en_a_unused, sb_en_b_unused;

  gcs_cfg #(.N(NUM_OUT), .STAGES(STAGES)) u_cfg (
    .clk(clk_cfg), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pll_lock(pll_lock), .en_pll(en_pll), .en_stby(en_stby),
    .eff_sel(eff_sel), .sb_sel(sb_sel), .stat(src_stat)
  );

  gcs_glitch_mux #(.STAGES(STAGES)) u_sbmux (
    .clk_a(clk_sys), .clk_b(clk_alt), .rst(rst), .sel_b(sb_sel),
    .clk_o(stby_clk), .en_a(sb_en_a_unused), .en_b(sb_en_b_unused)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_OUT; i++) begin : g_out
      gcs_glitch_mux #(.STAGES(STAGES)) u_omux (
        .clk_a(stby_clk), .clk_b(clk_pll[i]), .rst(rst), .sel_b(eff_sel[i]),
        .clk_o(clk_out[i]), .en_a(en_stby[i]), .en_b(en_pll[i])
      );
    end
  endgenerate
endmodule

// File: tb/dual_clk_selector_tb_top.sv
`timescale 1ns/1ps
module dual_clk_selector_tb_top;
  localparam real P_CFG = 10.0, P_SYS = 16.0, P_ALT = 22.0;
  localparam real P_PL0 = 6.0,  P_PL1 = 8.0;
  localparam real MIN_PH = 2.9;
  localparam int  SETTLE = 80;

  logic clk_cfg = 0, clk_sys = 0, clk_alt = 0;
  logic [1:0] clk_pll = 2'b00;
  logic rst = 1, wr_en = 0, pll_lock = 0;
  logic [4:0] wr_data = '0;
  logic [1:0] clk_out, src_stat;

  int errors = 0, checks = 0, glitches = 0;
  bit mon_on = 0;
  real last0 = 0.0, last1 = 0.0;

  always #(P_CFG/2) clk_cfg = ~clk_cfg;
  always #(P_SYS/2) clk_sys = ~clk_sys;
  always #(P_ALT/2) clk_alt = ~clk_alt;
  always #(P_PL0/2) clk_pll[0] = ~clk_pll[0];
  always #(P_PL1/2) clk_pll[1] = ~clk_pll[1];

  dual_clk_selector dut_i (
    .clk_cfg(clk_cfg), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pll_lock(pll_lock), .clk_sys(clk_sys), .clk_alt(clk_alt),
    .clk_pll(clk_pll), .clk_out(clk_out), .src_stat(src_stat)
  );

  // R6 glitch monitor: every phase of each output is timed
  always @(clk_out[0]) if (mon_on) begin
    if ($realtime - last0 < MIN_PH) glitches++;
    last0 = $realtime;
  end
  always @(clk_out[1]) if (mon_on) begin
    if ($realtime - last1 < MIN_PH) glitches++;
    last1 = $realtime;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_per(input string req, input int idx, input real exp);
    real t0, p;
    repeat (3) begin
      if (idx == 0) @(posedge clk_out[0]); else @(posedge clk_out[1]);
    end
    t0 = $realtime;
    if (idx == 0) @(posedge clk_out[0]); else @(posedge clk_out[1]);
    p = $realtime - t0;
    checks++;
    if (p < exp - 0.5 || p > exp + 0.5) begin
      errors++;
      $display("FAIL %s: out%0d period actual=%0.2f expected=%0.2f", req, idx, p, exp);
    end
  endtask

  task automatic wr(input logic [4:0] v);
    @(negedge clk_cfg); wr_en = 1; wr_data = v;
    @(negedge clk_cfg); wr_en = 0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk_cfg);
  endtask

  function automatic real exp_per(input int idx, input int code, input int sb, input bit lk);
    if (lk && code[idx]) return (idx == 0) ? P_PL0 : P_PL1;
    return sb ? P_ALT : P_SYS;
  endfunction

  task automatic chk_glitch(input string req);
    chk(req, glitches, 0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20) @(negedge clk_cfg);
    rst = 0;
    repeat (10) @(negedge clk_cfg);
    last0 = $realtime; last1 = $realtime; mon_on = 1;

    // R3 reset state
    chk("R3 status", int'(src_stat), 0);
    chk_per("R3 out0 standby", 0, P_SYS);
    chk_per("R3 out1 standby", 1, P_SYS);

    // R5 request held while lock low
    wr(5'b00011);
    settle();
    chk("R5 held status", int'(src_stat), 0);
    chk_per("R5 held out0", 0, P_SYS);
    chk_per("R5 held out1", 1, P_SYS);
    pll_lock = 1;
    settle();
    chk("R5 lock rise status", int'(src_stat), 3);
    chk_per("R5 lock rise out0", 0, P_PL0);
    chk_per("R5 lock rise out1", 1, P_PL1);
    pll_lock = 0;
    settle();
    chk("R5 lock loss status", int'(src_stat), 0);
    chk_per("R5 lock loss out0", 0, P_SYS);
    pll_lock = 1;
    wr(5'b00000);
    settle();

    // R7 status cannot move within four cycles of the write
    wr(5'b00001);
    repeat (3) @(negedge clk_cfg);
    chk("R7 early status", int'(src_stat), 0);
    settle();
    chk("R7 final status", int'(src_stat), 1);
    chk_glitch("R7 R6 switch glitch-free");

    // sweep: all select codes under both standby sources (R1 R2 R4 R8 R6)
    for (int sb = 0; sb < 2; sb++) begin
      for (int code = 0; code < 4; code++) begin
        wr({sb[0], 2'b00, code[1:0]});
        settle();
        chk($sformatf("R8 status sb=%0d code=%0d", sb, code), int'(src_stat), code);
        chk_per($sformatf("R1 R4 out0 sb=%0d code=%0d", sb, code), 0, exp_per(0, code, sb, 1'b1));
        chk_per($sformatf("R2 R4 out1 sb=%0d code=%0d", sb, code), 1, exp_per(1, code, sb, 1'b1));
        chk_glitch($sformatf("R6 sb=%0d code=%0d", sb, code));
      end
    end

    // R9 reserved bits ignored
    wr(5'b01100);
    settle();
    chk("R9 status", int'(src_stat), 0);
    chk_per("R9 out0", 0, P_SYS);
    chk_per("R9 out1", 1, P_SYS);
    wr(5'b01110);
    settle();
    chk("R9 status code 2", int'(src_stat), 2);
    chk_per("R9 out0 code 2", 0, P_SYS);
    chk_glitch("R6 final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule